// File: doc/BRIEF.md
# Infrared Manchester Frame Decoder

This block decodes 14-bit biphase remote-control frames from a demodulated infrared line that is active low. The raw line is first synchronized into the clock domain. A prescaled tick counter then measures the time between successive line edges. Each interval is judged to be one half-bit period or two, or it is rejected. From the resulting half-bit stream the block rebuilds the frame. A frame closes when the tick counter runs out after the last edge, and at that point the block checks the two leading start bits.

Accepted frames pass through an address filter. The filter takes one programmable address, or a wildcard that lets every address through. The 6-bit command, the 5-bit address and the toggle bit are held in output registers behind a valid flag. The flag stays up until the consumer pulses an acknowledge. Frames that close while the flag is still up are dropped. The nominal full-bit tick count T comes from the clock frequency and the prescaler: clock Hz / 1000 × 1728 / 1000 / prescaler, truncated to 8 bits. The tolerance D is T/6, using integer division.

Top module: `rc5_ir_decoder`

## Requirements
- R1: After reset, rx_valid is 0, and rx_cmd, rx_addr and rx_toggle are all 0.
- R2: While idle, only a falling edge of the synchronized line starts a frame. A rising edge in idle leaves the decoder idle and produces no result.
- R3: An edge interval of t ticks counts as two half-bits when T−D < t ≤ T+D, and as one half-bit when T/2−D ≤ t ≤ T/2+D. Intervals measured with the line stretched or shortened within these windows still decode.
- R4: An interval that falls outside both windows abandons the frame with no result. All further edges are ignored until the tick counter expires, and a following frame then decodes normally. A result appears only in the cycle after the tick counter expires.
- R5: A line bit of 1 is high in its first half and low in its second half, and a 0 is the opposite. Frame bit 13 is sent first. The command is frame bits 5:0, the address is bits 10:6 and the toggle is bit 11.
- R6: A frame whose final bit is 0 has no closing edge. It still decodes, because on expiry the missing last half-bit is filled with a 0.
- R7: A frame is reported only if both start bits, frame bits 13 and 12, are 1.
- R8: When addr_filter[7] is 1, every address is reported. Otherwise a frame is reported only when addr_filter equals the 5-bit address zero-extended to 8 bits.
- R9: While rx_valid is high and ack is low, rx_valid and the three result fields hold their values. A frame that closes in this state is discarded.
- R10: An ack pulse while rx_valid is high clears rx_valid in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ir_rx_n | input | 1 | Demodulated infrared line, active low, asynchronous |
| addr_filter | input | 8 | Bit 7 = accept all addresses; otherwise the address to match |
| ack | input | 1 | One-cycle pulse that consumes the held result |
| rx_valid | output | 1 | A decoded result is held |
| rx_cmd | output | 6 | Command field of the held frame |
| rx_addr | output | 5 | Address field of the held frame |
| rx_toggle | output | 1 | Toggle bit of the held frame |

## Verification
Nearly every internal fault shows up only when a frame closes, about 256 ticks after its last edge. A wrong half-bit count, edge parity or shift position either keeps rx_valid low for a good frame or raises it with wrong fields. A stuck idle or dead state blocks every later frame. A fault in the hold logic instead appears within one cycle of an ack, or of a frame that closes while the flag is up. The bench therefore compares the outputs against a behavioural timing model on every clock. It also checks the decoded fields after each frame.

// File: rtl/rc5_dec_pkg.sv
package rc5_dec_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_DEAD = 2'd2
   } rx_state_t;

   localparam int unsigned BIT_US     = 64 * 27;
   localparam int unsigned FRAME_BITS = 14;

   // Nominal ticks per full bit, truncated to eight bits.
   function automatic int unsigned full_bit_ticks(input int unsigned clk_hz,
                                                   input int unsigned prescale);
      logic [63:0] v;
      v = 64'(clk_hz) / 64'd1000 * 64'(BIT_US) / 64'd1000 / 64'(prescale);
      return {24'd0, v[7:0]};
   endfunction

endpackage

// File: rtl/rc5_dec_sync.sv
module rc5_dec_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic line,
   output logic edge_any,
   output logic fall,
   output logic rise
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rc5_dec_sync: STAGES must be at least 2");
   end

   logic [STAGES:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr <= '1;
      else        sr <= {sr[STAGES-1:0], din};
   end

   assign line     = sr[STAGES-1];
   assign edge_any = sr[STAGES-1] ^ sr[STAGES];
   assign fall     = sr[STAGES] & ~sr[STAGES-1];
   assign rise     = ~sr[STAGES] & sr[STAGES-1];
endmodule

// File: rtl/rc5_dec_timer.sv
module rc5_dec_timer #(
   parameter int PRESCALE = 256,
   parameter int TICK_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              restart,
   output logic [TICK_W-1:0] ticks,
   output logic              expire
);
   logic tick;

   if (PRESCALE == 1) begin : g_direct
      assign tick = 1'b1;
   end else begin : g_div
      localparam int PW = $clog2(PRESCALE);
      localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);
      logic [PW-1:0] pc;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                pc <= '0;
         else if (!run || restart)  pc <= '0;
         else if (pc == LAST)       pc <= '0;
         else                       pc <= pc + 1'b1;
      end
      assign tick = (pc == LAST);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               ticks <= '0;
      else if (!run || restart) ticks <= '0;
      else if (tick)            ticks <= ticks + 1'b1;
   end

   assign expire = run & tick & (&ticks);
endmodule

// File: rtl/rc5_dec_classify.sv
module rc5_dec_classify #(
   parameter int unsigned FULL_T = 216,
   parameter int          TICK_W = 8
) (
   input  logic [TICK_W-1:0] ticks,
   output logic [1:0]        halves
);
   localparam int unsigned TOL    = FULL_T / 6;
   localparam int unsigned HALF_T = FULL_T / 2;
   localparam int unsigned ONE_LO = HALF_T - TOL;
   localparam int unsigned ONE_HI = HALF_T + TOL;
   localparam int unsigned TWO_LO = FULL_T - TOL;
   localparam int unsigned TWO_HI = FULL_T + TOL;

   int unsigned tk;

   always_comb begin
      tk = int'(ticks);
      if (tk > TWO_HI || tk < ONE_LO) halves = 2'd0;
      else if (tk > TWO_LO)           halves = 2'd2;
      else if (tk > ONE_HI)           halves = 2'd0;
      else                            halves = 2'd1;
   end
endmodule

// File: rtl/rc5_ir_decoder.sv
module rc5_ir_decoder
   import rc5_dec_pkg::*;
#(
   parameter int unsigned CLK_HZ      = 36_000_000,
   parameter int unsigned PRESCALE    = 256,
   parameter int          SYNC_STAGES = 2,
   parameter int          TICK_W      = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ir_rx_n,
   input  logic [7:0] addr_filter,
   input  logic       ack,
   output logic       rx_valid,
   output logic [5:0] rx_cmd,
   output logic [4:0] rx_addr,
   output logic       rx_toggle
);
   localparam int unsigned FULL_T = full_bit_ticks(CLK_HZ, PRESCALE);
   localparam int          HALF_W = $clog2(2 * FRAME_BITS) + 1;
   localparam int          FW     = int'(FRAME_BITS);
   localparam logic [HALF_W-1:0] PAD_AT  = HALF_W'(2 * FRAME_BITS - 2);
   localparam logic [HALF_W-1:0] FULL_AT = HALF_W'(2 * FRAME_BITS - 1);

   if (FULL_T < 12) begin : g_bad_t
      $error("rc5_ir_decoder: full-bit tick count too small");
   end
   if (TICK_W < 8) begin : g_bad_w
      $error("rc5_ir_decoder: tick counter narrower than 8 bits");
   end

   rx_state_t         state;
   logic              line, edge_any, fall, rise;
   logic              in_idle, restart, expire;
   logic [TICK_W-1:0] ticks;
   logic [1:0]        halves;
   logic [HALF_W-1:0] half_cnt, fin_cnt;
   logic              parity;
   logic [FW-1:0]     shreg, fin_reg;
   logic              addr_ok, accept;

   rc5_dec_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(ir_rx_n),
      .line(line), .edge_any(edge_any), .fall(fall), .rise(rise)
   );

   assign in_idle = (state == ST_IDLE);
   assign restart = (state == ST_RUN) & edge_any;

   rc5_dec_timer #(.PRESCALE(int'(PRESCALE)), .TICK_W(TICK_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .run(~in_idle), .restart(restart),
      .ticks(ticks), .expire(expire)
   );

   rc5_dec_classify #(.FULL_T(FULL_T), .TICK_W(TICK_W)) u_class (
      .ticks(ticks), .halves(halves)
   );

   // Close-out view of the frame, with the silent last half filled in.
   always_comb begin
      if (half_cnt == PAD_AT) begin
         fin_cnt = FULL_AT;
         fin_reg = {shreg[FW-2:0], 1'b0};
      end else begin
         fin_cnt = half_cnt;
         fin_reg = shreg;
      end
      addr_ok = addr_filter[7] | (addr_filter == {3'b000, fin_reg[10:6]});
      accept  = expire & (fin_cnt == FULL_AT) & (&fin_reg[FW-1:FW-2])
              & ~rx_valid & addr_ok;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         half_cnt <= '0;
         parity   <= 1'b0;
         shreg    <= '0;
      end else if (expire) begin
         state    <= ST_IDLE;
         half_cnt <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (fall) begin
               state    <= ST_RUN;
               half_cnt <= '0;
               parity   <= 1'b1;
               shreg    <= '0;
            end
            ST_RUN: if (edge_any) begin
               parity <= ~parity;
               if (halves == 2'd0) begin
                  state    <= ST_DEAD;
                  half_cnt <= '0;
               end else begin
                  if (halves == 2'd2 || !half_cnt[0])
                     shreg <= {shreg[FW-2:0], parity};
                  half_cnt <= half_cnt + HALF_W'(halves);
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_valid  <= 1'b0;
         rx_cmd    <= '0;
         rx_addr   <= '0;
         rx_toggle <= 1'b0;
      end else if (accept) begin
         rx_valid  <= 1'b1;
         rx_cmd    <= fin_reg[5:0];
         rx_addr   <= fin_reg[10:6];
         rx_toggle <= fin_reg[11];
      end else if (ack) begin
         rx_valid  <= 1'b0;
      end
   end
endmodule

// File: rtl/rc5_ir_decoder_chk.sv
module rc5_ir_decoder_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       ack,
   input logic [7:0] addr_filter,
   input logic       rx_valid,
   input logic [5:0] rx_cmd,
   input logic [4:0] rx_addr,
   input logic       rx_toggle,
   input logic       expire,
   input logic       in_idle,
   input logic       rise
);
   assert_idle_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_idle && rise) |=> in_idle);

   assert_result_at_close_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_valid) |-> $past(expire));

   assert_filter_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rx_valid) && !$past(addr_filter[7]))
         |-> ($past(addr_filter) == {3'b000, rx_addr}));

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !ack) |=> (rx_valid && $stable(rx_cmd)
                              && $stable(rx_addr) && $stable(rx_toggle)));

   assert_ack_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && ack) |=> !rx_valid);
endmodule

bind rc5_ir_decoder rc5_ir_decoder_chk u_chk (
   .clk(clk), .rst_n(rst_n), .ack(ack), .addr_filter(addr_filter),
   .rx_valid(rx_valid), .rx_cmd(rx_cmd), .rx_addr(rx_addr),
   .rx_toggle(rx_toggle), .expire(expire), .in_idle(in_idle), .rise(rise)
);

// File: tb/tb_rc5_ir_decoder.sv
module tb_rc5_ir_decoder;
   localparam int unsigned CLK_HZ = 250_000;
   localparam int unsigned PRE    = 2;
   localparam int T  = int'((CLK_HZ / 1000 * 1728 / 1000 / PRE) % 256);
   localparam int D  = T / 6;
   localparam int H  = T * int'(PRE) / 2;
   localparam int EXP_CNT = 256 * int'(PRE) - 1;

   logic       clk = 1'b0, rst_n = 1'b0, ir_rx_n = 1'b1, ack = 1'b0;
   logic [7:0] addr_filter = 8'hFF;
   logic       rx_valid, rx_toggle;
   logic [5:0] rx_cmd;
   logic [4:0] rx_addr;

   int  checks = 0, fails = 0;
   bit  done = 0;

   always #2 clk = ~clk;

   rc5_ir_decoder #(.CLK_HZ(CLK_HZ), .PRESCALE(PRE)) dut (
      .clk(clk), .rst_n(rst_n), .ir_rx_n(ir_rx_n), .addr_filter(addr_filter),
      .ack(ack), .rx_valid(rx_valid), .rx_cmd(rx_cmd), .rx_addr(rx_addr),
      .rx_toggle(rx_toggle)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Behavioural timing model of the line decoder.
   int m_q0 = 1, m_q1 = 1, m_prev = 1, m_st = 0, m_cnt = 0;
   int m_halfs = 0, m_par = 0, m_sh = 0;
   int mv = 0, mc = 0, ma = 0, mt = 0;

   function automatic int halves_of(input int tk);
      if (tk > T + D || tk < T / 2 - D) return 0;
      if (tk > T - D) return 2;
      if (tk > T / 2 + D) return 0;
      return 1;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_q0 = 1; m_q1 = 1; m_prev = 1; m_st = 0; m_cnt = 0;
         m_halfs = 0; m_par = 0; m_sh = 0; mv = 0; mc = 0; ma = 0; mt = 0;
      end else begin
         int  line, ed, fl, h, s, n;
         bit  take, expd;
         line = m_q1; ed = int'(line != m_prev); fl = int'(m_prev == 1 && line == 0);
         take = 0;
         expd = (m_st != 0) && (m_cnt == EXP_CNT);
         if (expd) begin
            h = m_halfs; s = m_sh;
            if (h == 26) begin h = 27; s = (s << 1) & 16383; end
            if (h == 27 && ((s >> 12) & 3) == 3 && mv == 0 &&
                (addr_filter[7] || int'(addr_filter) == ((s >> 6) & 31))) begin
               take = 1; mc = s & 63; ma = (s >> 6) & 31; mt = (s >> 11) & 1;
            end
            m_st = 0; m_cnt = 0; m_halfs = 0;
         end else if (m_st == 0) begin
            if (fl != 0) begin m_st = 1; m_cnt = 0; m_sh = 0; m_halfs = 0; m_par = 1; end
         end else if (m_st == 1 && ed != 0) begin
            n = halves_of(m_cnt / int'(PRE));
            if (n == 0) begin m_st = 2; m_halfs = 0; end
            else begin
               if (n == 2 || (m_halfs % 2) == 0) m_sh = ((m_sh << 1) | m_par) & 16383;
               m_halfs = (m_halfs + n) % 64;
            end
            m_par = 1 - m_par; m_cnt = 0;
         end else begin
            m_cnt++;
         end
         if (take) mv = 1;
         else if (ack) mv = 0;
         m_prev = m_q1; m_q1 = m_q0; m_q0 = int'(ir_rx_n);
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(int'(rx_valid) == mv, "R9", "model valid", int'(rx_valid), mv);
         if (mv != 0) begin
            chk(int'(rx_cmd) == mc, "R5", "model cmd", int'(rx_cmd), mc);
            chk(int'(rx_addr) == ma, "R5", "model addr", int'(rx_addr), ma);
            chk(int'(rx_toggle) == mt, "R5", "model toggle", int'(rx_toggle), mt);
         end
      end
   end

   function automatic logic [13:0] mk(input logic t, input logic [4:0] a, input logic [5:0] c);
      return {2'b11, t, a, c};
   endfunction

   task automatic send(input logic [13:0] fr, input int hd, input int at, input int len);
      for (int k = 0; k < 28; k++) begin
         logic b;
         b = fr[13 - k / 2];
         ir_rx_n = (k % 2 == 0) ? b : ~b;
         repeat ((k == at) ? len : hd) @(negedge clk);
      end
      ir_rx_n = 1'b1;
      repeat (800) @(negedge clk);
   endtask

   task automatic expect_frame(input string req, input logic [13:0] fr);
      chk(rx_valid == 1'b1, req, "valid", int'(rx_valid), 1);
      chk(rx_cmd == fr[5:0], req, "cmd", int'(rx_cmd), int'(fr[5:0]));
      chk(rx_addr == fr[10:6], req, "addr", int'(rx_addr), int'(fr[10:6]));
      chk(rx_toggle == fr[11], req, "toggle", int'(rx_toggle), int'(fr[11]));
   endtask

   task automatic pulse_ack();
      ack = 1'b1;
      @(negedge clk);
      ack = 1'b0;
   endtask

   initial begin
      logic [13:0] fa, fb, fc;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(rx_valid == 1'b0, "R1", "valid after reset", int'(rx_valid), 0);
      chk(rx_cmd == 6'd0 && rx_addr == 5'd0 && rx_toggle == 1'b0, "R1",
          "fields after reset", int'({rx_toggle, rx_addr, rx_cmd}), 0);

      // R2: line held low past expiry, then a rising edge while idle
      ir_rx_n = 1'b0; repeat (1500) @(negedge clk);
      ir_rx_n = 1'b1; repeat (800) @(negedge clk);
      chk(rx_valid == 1'b0, "R2", "no result from idle rise", int'(rx_valid), 0);

      fa = mk(1'b1, 5'd5, 6'h2A);           // last bit 0: padding (R6)
      send(fa, H, -1, 0);
      expect_frame("R6", fa);

      fb = mk(1'b0, 5'd3, 6'h15);           // closes while result held
      send(fb, H, -1, 0);
      expect_frame("R9", fa);

      pulse_ack();
      chk(rx_valid == 1'b0, "R10", "valid after ack", int'(rx_valid), 0);

      fc = mk(1'b0, 5'h1F, 6'h15);          // last bit 1
      send(fc, H, -1, 0);
      expect_frame("R5", fc);
      pulse_ack();

      addr_filter = 8'd9;
      send(mk(1'b1, 5'd5, 6'h01), H, -1, 0);
      chk(rx_valid == 1'b0, "R8", "filtered address", int'(rx_valid), 0);
      fa = mk(1'b1, 5'd9, 6'h3F);
      send(fa, H, -1, 0);
      expect_frame("R8", fa);
      pulse_ack();
      addr_filter = 8'hFF;

      send({2'b10, 1'b0, 5'd2, 6'd4}, H, -1, 0);
      chk(rx_valid == 1'b0, "R7", "second start bit 0", int'(rx_valid), 0);

      send(mk(1'b0, 5'd4, 6'h0C), H, 10, 300);
      chk(rx_valid == 1'b0, "R4", "stretched half", int'(rx_valid), 0);
      ir_rx_n = 1'b0; repeat (100) @(negedge clk);
      ir_rx_n = 1'b1; repeat (800) @(negedge clk);
      chk(rx_valid == 1'b0, "R4", "short glitch", int'(rx_valid), 0);

      fa = mk(1'b1, 5'h11, 6'h33);
      send(fa, 240, -1, 0);
      expect_frame("R3", fa);
      pulse_ack();
      fb = mk(1'b0, 5'h0A, 6'h2B);
      send(fb, 200, -1, 0);
      expect_frame("R3", fb);
      pulse_ack();
      chk(rx_valid == 1'b0, "R10", "valid after final ack", int'(rx_valid), 0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; fails++;
         $display("FAIL R4 watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule